// File: doc/BRIEF.md
# Thermometer Error Detector

This block sits in the digital control loop of a regulator. Each regulation clock it receives a thermometer word that encodes the sampled output level, where one count equals one quantisation step of roughly 25 mV. It also receives a binary set-point code. The block counts the ones in the thermometer word and subtracts that count from the set-point. This gives a signed error.

The error magnitude is then sorted into one of four gain-selection states. The downstream controller uses that state to pick its proportional and integral coefficients. The sign is reported on its own as a direction flag. The error, the flag and the state are all registered once per clock.

The classifier comes in two variants, chosen by a parameter:
- **Bit-test variant (default).** It looks only at three fixed bits of the magnitude, in a fixed priority. This keeps the decision down to a few gates.
- **Range variant.** It OR-reduces bit groups, which gives true threshold ranges.

Malformed thermometer words are not rejected. Their ones are simply counted.

Top module: `therm_err_detect`

## Requirements
- R1: The measured count is the number of ones in `therm_i`, whatever their positions; a word with gaps (a bubble) is counted, never rejected.
- R2: `err_o` equals `ref_i` minus the measured count as a two's-complement value, and appears on the first rising clock edge after the inputs are applied; it never takes the most negative code of its width.
- R3: `err_neg_o` is 1 exactly when `err_o` is negative.
- R4: `state_o` is 2'b11 whenever bit 5 of the error magnitude is set; in both variants this implies a magnitude of at least 32.
- R5: In the bit-test variant, `state_o` is 2'b10 when magnitude bit 5 is clear and bit 3 is set.
- R6: In the bit-test variant, `state_o` is 2'b01 when magnitude bits 5 and 3 are clear and bit 0 is set.
- R7: `state_o` is 2'b00 when the error is zero. In the bit-test variant it is also 2'b00 whenever magnitude bits 5, 3 and 0 are all clear, for example at magnitudes 2 or 16.
- R8: In the range variant, `state_o` is 2'b11 for magnitudes 32..63, 2'b10 for 8..31, 2'b01 for 1..7 and 2'b00 for 0.
- R9: When `rst_n` goes low, all outputs go to zero at once, without waiting for a clock. After `rst_n` rises, the outputs stay zero through two more rising edges, and the first value is captured on the third edge.
- R10: The state depends only on the error magnitude, so errors of +e and -e give the same state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Regulation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| therm_i | input | 63 | Thermometer word for the sampled output level |
| ref_i | input | 6 | Binary set-point code |
| err_o | output | 7 | Registered signed error, set-point minus count |
| err_neg_o | output | 1 | Registered direction flag, 1 when the error is negative |
| state_o | output | 2 | Registered gain-selection state |

## Verification
The bench builds two copies of the block at the default 63-bit width: one with the bit-test classifier and one with the range classifier. Both copies receive the same stimulus.

With a six-bit set-point and a six-bit count, the full cross-product of 4096 error cases can be swept in a few thousand cycles. This covers every magnitude, both signs, the saturating extremes ±63, and the magnitudes where the two classifiers disagree. One third of the sweep uses scattered-bit words, so that counting is proven to be independent of bit position.

// File: rtl/tdet_pkg.sv
package tdet_pkg;

  typedef enum logic [1:0] {
    GS_HOLD   = 2'b00,
    GS_FINE   = 2'b01,
    GS_MID    = 2'b10,
    GS_COARSE = 2'b11
  } gain_state_e;

endpackage

// File: rtl/tdet_popcount.sv
module tdet_popcount #(
  parameter int THERM_W = 63,
  parameter int CNT_W   = $clog2(THERM_W + 1)
) (
  input  logic [THERM_W-1:0] therm,
  output logic [CNT_W-1:0]   count
);

  // Count of ones; any gap in the run (a bubble) still adds its ones.
  always_comb begin
    count = '0;
    for (int i = 0; i < THERM_W; i++) begin
      count = count + CNT_W'(therm[i]);
    end
  end

endmodule

// File: rtl/tdet_subtract.sv
module tdet_subtract #(
  parameter int CNT_W = 6,
  parameter int ERR_W = CNT_W + 1
) (
  input  logic [CNT_W-1:0]        setpoint,
  input  logic [CNT_W-1:0]        count,
  output logic signed [ERR_W-1:0] diff,
  output logic [CNT_W-1:0]        mag,
  output logic                    neg
);

  logic signed [ERR_W-1:0] sp_ext;
  logic signed [ERR_W-1:0] cnt_ext;
  logic signed [ERR_W-1:0] inv;

  always_comb begin
    sp_ext  = signed'({1'b0, setpoint});
    cnt_ext = signed'({1'b0, count});
    diff    = sp_ext - cnt_ext;
    neg     = diff[ERR_W-1];
    inv     = -diff;
    mag     = neg ? inv[CNT_W-1:0] : diff[CNT_W-1:0];
  end

endmodule

// File: rtl/tdet_classify.sv
module tdet_classify
  import tdet_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int COARSE_BIT = 5,
  parameter int MID_BIT    = 3,
  parameter bit BIT_TEST   = 1'b1
) (
  input  logic [CNT_W-1:0] mag,
  output gain_state_e      state
);

  generate
    if (BIT_TEST) begin : g_bit_test
      // Fixed-priority probe of three single bits.
      always_comb begin
        if (mag[COARSE_BIT])  state = GS_COARSE;
        else if (mag[MID_BIT]) state = GS_MID;
        else if (mag[0])       state = GS_FINE;
        else                   state = GS_HOLD;
      end
    end else begin : g_range
      logic coarse_hit;
      logic mid_hit;
      logic fine_hit;
      always_comb begin
        coarse_hit = |mag[CNT_W-1:COARSE_BIT];
        mid_hit    = |mag[COARSE_BIT-1:MID_BIT];
        fine_hit   = |mag[MID_BIT-1:0];
        if (coarse_hit)    state = GS_COARSE;
        else if (mid_hit)  state = GS_MID;
        else if (fine_hit) state = GS_FINE;
        else               state = GS_HOLD;
      end
    end
  endgenerate

endmodule

// File: rtl/therm_err_detect.sv
module therm_err_detect
  import tdet_pkg::*;
#(
  parameter int THERM_W    = 63,
  parameter int COARSE_BIT = 5,
  parameter int MID_BIT    = 3,
  parameter bit BIT_TEST   = 1'b1,
  localparam int CNT_W     = $clog2(THERM_W + 1),
  localparam int ERR_W     = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [THERM_W-1:0]      therm_i,
  input  logic [CNT_W-1:0]        ref_i,
  output logic signed [ERR_W-1:0] err_o,
  output logic                    err_neg_o,
  output logic [1:0]              state_o
);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // Datapath
  logic [CNT_W-1:0]        count;
  logic signed [ERR_W-1:0] diff;
  logic [CNT_W-1:0]        mag;
  logic                    neg;
  gain_state_e             state_d;

  tdet_popcount #(.THERM_W(THERM_W), .CNT_W(CNT_W)) u_count (
    .therm (therm_i),
    .count (count)
  );

  tdet_subtract #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_sub (
    .setpoint (ref_i),
    .count    (count),
    .diff     (diff),
    .mag      (mag),
    .neg      (neg)
  );

  tdet_classify #(
    .CNT_W(CNT_W), .COARSE_BIT(COARSE_BIT), .MID_BIT(MID_BIT), .BIT_TEST(BIT_TEST)
  ) u_cls (
    .mag   (mag),
    .state (state_d)
  );

  // Next-state and registers
  logic                    upd_en;
  logic signed [ERR_W-1:0] err_d, err_q;
  logic                    neg_d, neg_q;
  gain_state_e             st_d, st_q;

  always_comb begin
    upd_en = 1'b1;
    err_d  = diff;
    neg_d  = neg;
    st_d   = state_d;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      err_q <= '0;
      neg_q <= 1'b0;
      st_q  <= GS_HOLD;
    end else if (upd_en) begin
      err_q <= err_d;
      neg_q <= neg_d;
      st_q  <= st_d;
    end
  end

  assign err_o     = err_q;
  assign err_neg_o = neg_q;
  assign state_o   = st_q;

  // Assertions
  logic [ERR_W-1:0] mag_chk;
  always_comb mag_chk = err_q[ERR_W-1] ? ERR_W'(-err_q) : ERR_W'(err_q);

  assert_no_min_code_R2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    err_q != signed'({1'b1, {(ERR_W-1){1'b0}}}));

  assert_sign_flag_R3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    neg_q == err_q[ERR_W-1]);

  assert_coarse_mag_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (st_q == GS_COARSE) |-> (mag_chk >= ERR_W'(1 << COARSE_BIT)));

  assert_mid_below_coarse_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (st_q == GS_MID) |-> (mag_chk < ERR_W'(1 << COARSE_BIT)));

  assert_fine_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (st_q == GS_FINE) |-> (mag_chk != '0));

  assert_zero_holds_R7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (err_q == '0) |-> (st_q == GS_HOLD));

endmodule

// File: tb/therm_err_detect_test.sv
module therm_err_detect_test;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [62:0]       therm = '0;
  logic [5:0]        refc = '0;
  logic signed [6:0] err_a, err_b;
  logic              neg_a, neg_b;
  logic [1:0]        st_a, st_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  therm_err_detect #(.BIT_TEST(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .therm_i(therm), .ref_i(refc),
    .err_o(err_a), .err_neg_o(neg_a), .state_o(st_a)
  );

  therm_err_detect #(.BIT_TEST(1'b0)) uut_rng (
    .clk(clk), .rst_n(rst_n), .therm_i(therm), .ref_i(refc),
    .err_o(err_b), .err_neg_o(neg_b), .state_o(st_b)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [62:0] make_word(input int cnt, input int mode, input int seed);
    logic [62:0] w = '0;
    for (int i = 0; i < 63; i++) begin
      case (mode)
        0: w[i] = (i < cnt);
        1: w[i] = (i >= 63 - cnt);
        default: w[i] = (((i * 37) + seed) % 63) < cnt;
      endcase
    end
    return w;
  endfunction

  function automatic int bit_state(input int m);
    if (m[5]) return 3;
    if (m[3]) return 2;
    if (m[0]) return 1;
    return 0;
  endfunction

  function automatic int rng_state(input int m);
    if (m >= 32) return 3;
    if (m >= 8)  return 2;
    if (m >= 1)  return 1;
    return 0;
  endfunction

  // Drive at a falling edge; outputs are sampled one falling edge later.
  task automatic apply_and_check(input int r, input int cnt, input int mode);
    int e, m, sb, sr;
    string et, st;
    refc  = 6'(r);
    therm = make_word(cnt, mode, r);
    @(negedge clk);
    e  = r - cnt;
    m  = (e < 0) ? -e : e;
    sb = bit_state(m);
    sr = rng_state(m);
    et = (mode == 2) ? "R1" : "R2";
    check(et, int'(err_a), e);
    check(et, int'(err_b), e);
    check("R3", int'(neg_a), (e < 0) ? 1 : 0);
    check("R3", int'(neg_b), (e < 0) ? 1 : 0);
    case (sb)
      3: st = "R4";
      2: st = "R5";
      1: st = "R6";
      default: st = "R7";
    endcase
    check(st, int'(st_a), sb);
    check("R8", int'(st_b), sr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s1, s2;
    // R9: outputs zero during reset
    repeat (3) @(negedge clk);
    check("R9", int'(err_a), 0);
    check("R9", int'(st_a), 0);
    check("R9", int'(neg_a), 0);
    refc  = 6'd40;
    therm = '0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", int'(err_a), 0);
    @(negedge clk);
    check("R9", int'(err_a), 0);
    @(negedge clk);
    check("R9", int'(err_a), 40);

    // Exhaustive sweep of set-point by count, three word shapes (R1..R8)
    for (int r = 0; r < 64; r++) begin
      for (int c = 0; c < 64; c++) begin
        apply_and_check(r, c, (r + c) % 3);
      end
    end

    // R10: mirrored errors give the same state
    for (int k = 1; k < 64; k++) begin
      refc = 6'(k); therm = make_word(0, 0, 0);
      @(negedge clk);
      s1 = int'(st_a); s2 = int'(st_b);
      refc = 6'd0; therm = make_word(k, 2, k);
      @(negedge clk);
      check("R10", int'(st_a), s1);
      check("R10", int'(st_b), s2);
    end

    // R9: asynchronous clear while running
    refc = 6'd63; therm = '0;
    @(negedge clk);
    check("R2", int'(err_a), 63);
    #1 rst_n = 1'b0;
    #0.5;
    check("R9", int'(err_a), 0);
    check("R9", int'(st_a), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9", int'(st_b), 0);
    @(negedge clk);
    check("R9", int'(st_b), 3);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule